// File: doc/BRIEF.md
# Line sag and fault detector

This block watches two streams of signed 24-bit instantaneous samples, one for line voltage and one for line current. A pair arrives together on each ADC cycle, marked by a one-cycle valid strobe. Each channel has a programmable magnitude threshold and a programmable window length, counted in accepted strobes. Within each window the block counts the samples whose saturated absolute value lies strictly under the threshold. If that count is strictly more than half of the window, the channel raises a sticky flag. The voltage channel drives the sag flag and the current channel drives the fault flag.

Windows follow each other back to back and never overlap. Both counters of a channel return to zero when a window closes. A window length of zero holds that channel idle with its counters at zero. The threshold uses the same scale as the mean absolute instantaneous value of the signal. The sample input is a plain valid strobe. The block accepts every strobe and never stalls the source, so it has no ready output and no back-pressure.

Top module: `sag_fault_detect`

## Requirements
- R1: The voltage and current channels are independent. Each has its own threshold and window length, and each drives only its own flag.
- R2: Sample magnitude is the absolute value of the 24-bit two's complement code, with saturation. The code 0x800000 maps to 0x7FFFFF. Negative samples count by their magnitude.
- R3: A sample counts as low only when its magnitude is strictly less than the threshold. A magnitude equal to the threshold is not low.
- R4: A window raises its flag only when the number of low samples is strictly greater than half the window length. For a length of 4, two low samples are not enough and three are. For a length of 5, three are enough.
- R5: Window length is counted in valid strobes only. Cycles without a strobe neither advance the window nor add low samples.
- R6: A window length of zero disables that channel. Its flag never sets, however many low samples arrive.
- R7: Windows are consecutive and non-overlapping. Low counts from one window are never carried into the next.
- R8: A flag stays set until a one is driven on that channel's clear input. It reads zero in the cycle after the clear.
- R9: When a detection and a clear fall in the same cycle, the flag ends up set.
- R10: A flag rises in the cycle after the strobe that carries the last sample of the window. It never rises in a cycle that follows a cycle without a strobe.
- R11: After reset both flags read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Strobe: one sample pair is present this cycle |
| v_sample | input | 24 | Voltage sample, two's complement |
| i_sample | input | 24 | Current sample, two's complement |
| v_level | input | 24 | Voltage threshold, unsigned magnitude |
| v_window | input | 16 | Voltage window length in strobes, 0 disables |
| i_level | input | 24 | Current threshold, unsigned magnitude |
| i_window | input | 16 | Current window length in strobes, 0 disables |
| v_clr | input | 1 | Write-one clear of the sag flag |
| i_clr | input | 1 | Write-one clear of the fault flag |
| v_sag | output | 1 | Sticky voltage sag flag |
| i_fault | output | 1 | Sticky current fault flag |

## Verification
Each flag is a single register. Its new value is due one clock edge after the cycle that carries the closing strobe or the clear, and it must not change in any other cycle. The driver applies one cycle of stimulus at the falling edge and queues the flag pair expected after the next rising edge. The monitor compares that pair a short delay after the rising edge. Every cycle is checked, idle cycles included, so a flag that rises early, rises late or fails to clear shows up in the exact cycle where it goes wrong.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int SMP_W_DEF = 24;
  localparam int WIN_W_DEF = 16;

  typedef enum logic {
    CH_VOLT = 1'b0,
    CH_CURR = 1'b1
  } chan_e;
endpackage

// File: rtl/sag_abs.sv
module sag_abs #(
  parameter int W = 24
) (
  input  logic [W-1:0] smp,
  output logic [W-1:0] mag
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (smp == MOST_NEG)    mag = MOST_POS;
    else if (smp[W-1])      mag = (~smp) + 1'b1;
    else                    mag = smp;
  end
endmodule

// File: rtl/sag_window.sv
module sag_window #(
  parameter int W     = 24,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [W-1:0]     mag,
  input  logic [W-1:0]     level,
  input  logic [WIN_W-1:0] win_len,
  output logic             detect
);
  localparam int CW = WIN_W + 2;

  logic [WIN_W-1:0] cyc_q, low_q;
  logic             enabled, below, last;
  logic [WIN_W:0]   low_nxt;

  always_comb begin
    enabled = (win_len != '0);
    below   = (mag < level);
    low_nxt = {1'b0, low_q} + {{WIN_W{1'b0}}, below};
    last    = ({1'b0, cyc_q} + 1'b1) >= {1'b0, win_len};
    detect  = valid && enabled && last &&
              ({low_nxt, 1'b0} > CW'(win_len));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      low_q <= '0;
    end else if (!enabled) begin
      cyc_q <= '0;
      low_q <= '0;
    end else if (valid) begin
      if (last) begin
        cyc_q <= '0;
        low_q <= '0;
      end else begin
        cyc_q <= cyc_q + 1'b1;
        low_q <= low_nxt[WIN_W-1:0];
      end
    end
  end

  AST_LOW_WITHIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    low_q <= cyc_q); // R7

  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && enabled) |=> $stable(cyc_q) && $stable(low_q)); // R5

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> (cyc_q == '0)); // R6
endmodule

// File: rtl/sag_sticky.sv
module sag_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set | (flag & ~clr);
  end

  AST_STAYS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R8

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && clr && !set) |=> !flag); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R9
endmodule

// File: rtl/sag_fault_detect.sv
module sag_fault_detect
  import sag_pkg::*;
#(
  parameter int SMP_W = SMP_W_DEF,
  parameter int WIN_W = WIN_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] v_sample,
  input  logic [SMP_W-1:0] i_sample,
  input  logic [SMP_W-1:0] v_level,
  input  logic [WIN_W-1:0] v_window,
  input  logic [SMP_W-1:0] i_level,
  input  logic [WIN_W-1:0] i_window,
  input  logic             v_clr,
  input  logic             i_clr,
  output logic             v_sag,
  output logic             i_fault
);
  localparam int NCH = 2;

  logic [SMP_W-1:0] smp_a [NCH];
  logic [SMP_W-1:0] lvl_a [NCH];
  logic [WIN_W-1:0] win_a [NCH];
  logic             clr_a [NCH];
  logic [SMP_W-1:0] mag_a [NCH];
  logic             det_a [NCH];
  logic             flg_a [NCH];

  always_comb begin
    smp_a[CH_VOLT] = v_sample;  smp_a[CH_CURR] = i_sample;
    lvl_a[CH_VOLT] = v_level;   lvl_a[CH_CURR] = i_level;
    win_a[CH_VOLT] = v_window;  win_a[CH_CURR] = i_window;
    clr_a[CH_VOLT] = v_clr;     clr_a[CH_CURR] = i_clr;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sag_abs #(.W(SMP_W)) u_abs (
      .smp (smp_a[c]),
      .mag (mag_a[c])
    );

    sag_window #(.W(SMP_W), .WIN_W(WIN_W)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (smp_valid),
      .mag     (mag_a[c]),
      .level   (lvl_a[c]),
      .win_len (win_a[c]),
      .detect  (det_a[c])
    );

    sag_sticky u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (det_a[c]),
      .clr   (clr_a[c]),
      .flag  (flg_a[c])
    );
  end

  assign v_sag   = flg_a[CH_VOLT];
  assign i_fault = flg_a[CH_CURR];

  AST_NO_RISE_IDLE_V: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !v_sag) |=> !v_sag); // R10

  AST_NO_RISE_IDLE_I: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !i_fault) |=> !i_fault); // R10

  AST_DISABLED_V: assert property (@(posedge clk) disable iff (!rst_n)
    (v_window == '0 && !v_sag) |=> !v_sag); // R6

  AST_DISABLED_I: assert property (@(posedge clk) disable iff (!rst_n)
    (i_window == '0 && !i_fault) |=> !i_fault); // R6
endmodule

// File: tb/sag_fault_detect_bench.sv
`timescale 1ns/1ps
module sag_fault_detect_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [23:0] v_sample = '0, i_sample = '0;
  logic [23:0] v_level = '0, i_level = '0;
  logic [15:0] v_window = '0, i_window = '0;
  logic        v_clr = 1'b0, i_clr = 1'b0;
  logic        v_sag, i_fault;

  always #5 clk = ~clk;

  sag_fault_detect u_sag_fault_detect (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .v_sample(v_sample), .i_sample(i_sample),
    .v_level(v_level), .v_window(v_window),
    .i_level(i_level), .i_window(i_window),
    .v_clr(v_clr), .i_clr(i_clr),
    .v_sag(v_sag), .i_fault(i_fault)
  );

  typedef struct {
    bit    v;
    bit    i;
    string tag;
  } exp_t;

  exp_t  sb[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  int    mcyc [2];
  int    mlow [2];
  bit    mflg [2];

  // Reference per channel, built from R2..R9
  task automatic model_ch(input int ch, input bit vld, input logic [23:0] s,
                          input logic [23:0] lvl, input int win, input bit clr);
    longint mag;
    bit     det;
    det = 1'b0;
    if (s == 24'h800000)   mag = 64'h7FFFFF;
    else if (s[23])        mag = 64'h1000000 - longint'(s);
    else                   mag = longint'(s);
    if (win == 0) begin
      mcyc[ch] = 0; mlow[ch] = 0;
    end else if (vld) begin
      int low2;
      low2 = mlow[ch] + ((mag < longint'(lvl)) ? 1 : 0);
      if (mcyc[ch] + 1 >= win) begin
        det = (2 * low2 > win);
        mcyc[ch] = 0; mlow[ch] = 0;
      end else begin
        mcyc[ch] = mcyc[ch] + 1; mlow[ch] = low2;
      end
    end
    mflg[ch] = det | (mflg[ch] & ~clr);
  endtask

  // Driver: one cycle of stimulus, expected result queued
  task automatic step(input bit vld, input logic [23:0] vs, input logic [23:0] is,
                      input bit vc, input bit ic, input string tag);
    exp_t e;
    smp_valid = vld; v_sample = vs; i_sample = is; v_clr = vc; i_clr = ic;
    model_ch(0, vld, vs, v_level, int'(v_window), vc);
    model_ch(1, vld, is, i_level, int'(i_window), ic);
    e.v = mflg[0]; e.i = mflg[1]; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    smp_valid = 1'b0; v_clr = 1'b0; i_clr = 1'b0;
  endtask

  task automatic clear_both(input string tag);
    step(1'b0, 24'd0, 24'd0, 1'b1, 1'b1, tag);
  endtask

  // Monitor: compare after the rising edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (v_sag !== e.v || i_fault !== e.i) begin
        n_bad++;
        $display("FAIL %s: v_sag/i_fault = %b/%b, expected %b/%b",
                 e.tag, v_sag, i_fault, e.v, e.i);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual running, expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    mcyc[0] = 0; mcyc[1] = 0; mlow[0] = 0; mlow[1] = 0;
    mflg[0] = 0; mflg[1] = 0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (v_sag !== 1'b0 || i_fault !== 1'b0) begin
      n_bad++;
      $display("FAIL R11: flags %b/%b in reset, expected 0/0", v_sag, i_fault);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (v_sag !== 1'b0 || i_fault !== 1'b0) begin
      n_bad++;
      $display("FAIL R11: flags %b/%b after reset, expected 0/0", v_sag, i_fault);
    end

    // R4 / R1: window 4, voltage 2 low, current 3 low
    v_level = 24'd100; i_level = 24'd100; v_window = 16'd4; i_window = 16'd4;
    step(1, 24'd10,  24'd10,  0, 0, "R4");
    step(1, 24'd10,  24'd10,  0, 0, "R4");
    step(1, 24'd500, 24'd10,  0, 0, "R4");
    step(1, 24'd500, 24'd500, 0, 0, "R1");
    // R8: flag holds while idle, then clears
    step(0, 24'd0, 24'd0, 0, 0, "R8");
    step(0, 24'd0, 24'd0, 0, 0, "R8");
    clear_both("R8");

    // R7: two windows of 2/4 low each must not merge
    for (int w = 0; w < 2; w++) begin
      step(1, 24'd500, 24'd500, 0, 0, "R7");
      step(1, 24'd500, 24'd500, 0, 0, "R7");
      step(1, 24'd5,   24'd5,   0, 0, "R7");
      step(1, 24'd5,   24'd5,   0, 0, "R7");
    end

    // R4 odd window of 5: 3 low sets voltage, 2 low current stays clear
    v_window = 16'd5; i_window = 16'd5;
    step(1, 24'd1, 24'd1,   0, 0, "R4");
    step(1, 24'd1, 24'd1,   0, 0, "R4");
    step(1, 24'd1, 24'd900, 0, 0, "R4");
    step(1, 24'd900, 24'd900, 0, 0, "R4");
    step(1, 24'd900, 24'd900, 0, 0, "R10");
    clear_both("R8");

    // R3: magnitude equal to threshold is not low
    v_window = 16'd4; i_window = 16'd4;
    for (int k = 0; k < 4; k++)
      step(1, 24'd100, 24'hFFFF9C, 0, 0, "R3");
    // R2: negative samples below threshold count by magnitude
    for (int k = 0; k < 4; k++)
      step(1, 24'hFFFFCE, 24'hFFFF9D, 0, 0, "R2");
    clear_both("R2");

    // R2 saturation: most negative code against 0x800000 and 0x7FFFFF
    v_level = 24'h800000; i_level = 24'h7FFFFF;
    for (int k = 0; k < 4; k++)
      step(1, 24'h800000, 24'h800000, 0, 0, "R2");
    clear_both("R2");
    v_level = 24'd100; i_level = 24'd100;

    // R5: idle cycles do not advance the window
    step(1, 24'd3, 24'd3, 0, 0, "R5");
    for (int k = 0; k < 5; k++) step(0, 24'd3, 24'd3, 0, 0, "R5");
    step(1, 24'd3, 24'd3, 0, 0, "R5");
    step(0, 24'd3, 24'd3, 0, 0, "R5");
    step(1, 24'd3, 24'd3, 0, 0, "R5");
    step(0, 24'd3, 24'd3, 0, 0, "R5");
    step(1, 24'd3, 24'd3, 0, 0, "R10");
    step(0, 24'd3, 24'd3, 0, 0, "R10");
    clear_both("R8");

    // R6: window zero disables voltage, current still works
    v_window = 16'd0;
    for (int k = 0; k < 10; k++)
      step(1, 24'd0, 24'd0, 0, 0, "R6");
    clear_both("R6");
    v_window = 16'd4;

    // R9: clear and detection in the same cycle, detection wins
    step(1, 24'd0, 24'd0, 0, 0, "R9");
    step(1, 24'd0, 24'd0, 0, 0, "R9");
    step(1, 24'd0, 24'd0, 0, 0, "R9");
    step(1, 24'd0, 24'd0, 1, 1, "R9");
    step(0, 24'd0, 24'd0, 0, 0, "R9");
    // R8: clear one channel only
    step(0, 24'd0, 24'd0, 1, 0, "R8");
    step(0, 24'd0, 24'd0, 0, 1, "R8");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule